// File: doc/BRIEF.md
# Buffered-reload two-channel PWM generator

This block produces two edge-aligned pulse-width-modulated outputs that share one period counter. Software programs a shared period, a duty value for each channel and a control byte through a small synchronous register port. Period and duty values are first held in buffer registers. They are moved into the working registers, which drive the waveform, only at scheduled reload points and only when software has armed the transfer.

A reload point falls at the end of every 1st, 2nd, 4th or 8th PWM cycle, as chosen by a two-bit interval field in the control byte. That field is double-buffered as well. A newly written interval is adopted only when the interval already running completes. This happens whether or not a period or duty transfer is armed, so a change of interval can never cut an interval short.

The per-channel disable bits and polarity bits act on the next clock, without waiting for a reload. A disabled channel drives its inactive level while the counter keeps running. The two low control bits are storage only and read back as written.

Top module: `pwm2_reload_top`

## Requirements
- R1: After reset the control register (address 0) reads 8'h0C, the period buffer reads the PER_RST parameter (default 10), both duty buffers and the arm flag read 0, and both outputs are 0.
- R2: The shared counter steps from 0 to period-1 and then wraps to 0, and a working period of 0 holds it at 0. A channel is active in a clock when the counter is below its working duty. The output shows that clock's level one clock later (registered output).
- R3: Control bits [7:6] pick the reload interval: 00 reloads at the end of every PWM cycle, 01 every 2nd, 10 every 4th and 11 every 8th. The first interval after reset uses 00.
- R4: A newly written interval value is adopted only at the reload point that ends the interval already running, whether or not the arm flag is set.
- R5: Register map: 0 control, 1 period buffer, 2 channel-0 duty buffer, 3 channel-1 duty buffer, 4 arm flag in bit 0. Addresses 5 to 7 read 0 and ignore writes. Read data for the address present in a clock appears one clock later. Reading the control register returns the buffered byte as written, including an interval value not yet in use.
- R6: At a reload point with the arm flag set, the period and both duty buffers are copied into the working registers and the arm flag clears in the same clock. At a reload point without the arm flag, and at all other times, the working values hold.
- R7: Control bit 4 (channel 0) and bit 5 (channel 1) disable a channel when 1: its output then shows the inactive level from the next clock on, and the counter keeps running. Writing 0 restores the waveform.
- R8: Control bit 2 (channel 0) and bit 3 (channel 1) set the polarity. With 1 the output is high while the channel is active, and with 0 it is low while active. The inactive level is always the inverse.
- R9: Writing address 4 sets the arm flag to written bit 0. A write that lands in the same clock as the hardware clear takes precedence over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for the previous clock's address |
| pwm_out | output | 2 | Channel outputs, bit 0 is channel 0 |

## Verification
A corrupted working period or working duty shows at the outputs within one PWM cycle, as a wrong wrap point or a wrong edge position. A scheduler whose cycle count or interval is off shows up at the first armed transfer: the new duty appears one or more PWM cycles early or late. An arm flag that fails to clear, or clears at the wrong time, is visible immediately on an address-4 read, and at the next reload point it causes an extra transfer or a missed one. Disable or polarity faults change the output level on the very next clock.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;
  localparam int LF_W   = 2;
  localparam int CTRL_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd1;
  localparam logic [ADDR_W-1:0] A_DTY0 = 3'd2;
  localparam logic [ADDR_W-1:0] A_DTY1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_ARM  = 3'd4;

  // control byte field positions
  localparam int LF_LSB  = 6;
  localparam int DIS_LSB = 4;
  localparam int POL_LSB = 2;

  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h0C;
endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
  import pwm2_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PER_RST = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         xfer_i,
  output logic [CTRL_W-1:0]            ctrl_q,
  output logic [DATA_W-1:0]            per_b,
  output logic [NCH-1:0][DATA_W-1:0]   duty_b,
  output logic                         arm_q,
  output logic [DATA_W-1:0]            rdata
);
  logic [DATA_W-1:0] rd_mux;
  logic              arm_wr;

  assign arm_wr = wr_en && (addr == A_ARM);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      per_b  <= DATA_W'(PER_RST);
      duty_b <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL: ctrl_q    <= wdata[CTRL_W-1:0];
        A_PER:  per_b     <= wdata;
        A_DTY0: duty_b[0] <= wdata;
        A_DTY1: duty_b[1] <= wdata;
        default: ;
      endcase
    end
  end

  // software write outranks the hardware clear (R9)
  always_ff @(posedge clk) begin
    if (rst)         arm_q <= 1'b0;
    else if (arm_wr) arm_q <= wdata[0];
    else if (xfer_i) arm_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_mux = DATA_W'(ctrl_q);
      A_PER:   rd_mux = per_b;
      A_DTY0:  rd_mux = duty_b[0];
      A_DTY1:  rd_mux = duty_b[1];
      A_ARM:   rd_mux = DATA_W'(arm_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  assert_arm_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    arm_wr |=> (arm_q == $past(wdata[0])));

  assert_ctrl_buffered_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_CTRL) |=> (ctrl_q == $past(wdata[CTRL_W-1:0])));
endmodule

// File: rtl/pwm2_sched.sv
module pwm2_sched
  import pwm2_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PER_RST = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LF_W-1:0]              lf_b,
  input  logic                         arm_i,
  input  logic [DATA_W-1:0]            per_b,
  input  logic [NCH-1:0][DATA_W-1:0]   duty_b,
  output logic                         xfer_o,
  output logic [DATA_W-1:0]            cnt_o,
  output logic [NCH-1:0][DATA_W-1:0]   duty_w
);
  localparam int MAX_IV = 1 << ((1 << LF_W) - 1);
  localparam int CYC_W  = $clog2(MAX_IV);

  logic [DATA_W-1:0] cnt_q;
  logic [DATA_W-1:0] per_w;
  logic [LF_W-1:0]   lf_w;
  logic [CYC_W-1:0]  cyc_q;
  logic [CYC_W-1:0]  iv_last;
  logic              per_end;
  logic              reload;

  always_comb begin
    iv_last = CYC_W'((32'd1 << lf_w) - 32'd1);
    per_end = (per_w == '0) || (cnt_q == per_w - DATA_W'(1));
    reload  = per_end && (cyc_q == iv_last);
  end

  assign xfer_o = reload && arm_i;
  assign cnt_o  = cnt_q;

  // edge-aligned period counter
  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (per_end) cnt_q <= '0;
    else              cnt_q <= cnt_q + DATA_W'(1);
  end

  // completed-cycle counter and interval adoption (R3, R4)
  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q <= '0;
      lf_w  <= '0;
    end else if (reload) begin
      cyc_q <= '0;
      lf_w  <= lf_b;
    end else if (per_end) begin
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  // armed transfer of period and duty (R6)
  always_ff @(posedge clk) begin
    if (rst) begin
      per_w  <= DATA_W'(PER_RST);
      duty_w <= '0;
    end else if (xfer_o) begin
      per_w  <= per_b;
      duty_w <= duty_b;
    end
  end

  assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (rst)
    (per_w != '0) |-> (cnt_q < per_w));

  assert_cyc_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cyc_q <= iv_last);

  assert_lf_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !reload |=> $stable(lf_w));

  assert_working_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !xfer_o |=> ($stable(per_w) && $stable(duty_w)));
endmodule

// File: rtl/pwm2_chan.sv
module pwm2_chan #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [DATA_W-1:0] duty_i,
  input  logic              dis_i,
  input  logic              pol_i,
  output logic              out_q
);
  logic active;

  assign active = (cnt_i < duty_i) && !dis_i;

  // reset level: inactive under positive polarity
  always_ff @(posedge clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= active ? pol_i : ~pol_i;
  end

  assert_disabled_inactive_R7: assert property (@(posedge clk) disable iff (rst)
    dis_i |=> (out_q == ~$past(pol_i)));

  assert_zero_duty_inactive_R8: assert property (@(posedge clk) disable iff (rst)
    (duty_i == '0) |=> (out_q == ~$past(pol_i)));
endmodule

// File: rtl/pwm2_reload_top.sv
module pwm2_reload_top
  import pwm2_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PER_RST = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        pwm_out
);
  logic [CTRL_W-1:0]          ctrl_q;
  logic [DATA_W-1:0]          per_b;
  logic [NCH-1:0][DATA_W-1:0] duty_b;
  logic [NCH-1:0][DATA_W-1:0] duty_w;
  logic [DATA_W-1:0]          cnt;
  logic                       arm_q;
  logic                       xfer;

  pwm2_regs #(.DATA_W(DATA_W), .PER_RST(PER_RST)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .xfer_i(xfer), .ctrl_q(ctrl_q), .per_b(per_b), .duty_b(duty_b),
    .arm_q(arm_q), .rdata(rdata)
  );

  pwm2_sched #(.DATA_W(DATA_W), .PER_RST(PER_RST)) u_sched (
    .clk(clk), .rst(rst), .lf_b(ctrl_q[LF_LSB +: LF_W]), .arm_i(arm_q),
    .per_b(per_b), .duty_b(duty_b), .xfer_o(xfer), .cnt_o(cnt),
    .duty_w(duty_w)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwm2_chan #(.DATA_W(DATA_W)) u_chan (
      .clk(clk), .rst(rst), .cnt_i(cnt), .duty_i(duty_w[ch]),
      .dis_i(ctrl_q[DIS_LSB + ch]), .pol_i(ctrl_q[POL_LSB + ch]),
      .out_q(pwm_out[ch])
    );
  end

  assert_arm_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (xfer && !(wr_en && addr == A_ARM)) |=> !arm_q);
endmodule

// File: tb/pwm2_reload_top_bench.sv
module pwm2_reload_top_bench;
  localparam int DW = 8;
  localparam int PR = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [2:0]    addr = 3'd0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [1:0]    pwm_out;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference state derived from the requirements
  logic [7:0]    m_ctrl;
  logic [DW-1:0] m_per_b, m_per_w, m_cnt;
  logic [DW-1:0] m_db [2];
  logic [DW-1:0] m_dw [2];
  logic [1:0]    m_lf;
  int            m_cyc;
  bit            m_arm;
  logic [1:0]    e_out;
  logic [DW-1:0] e_rd;

  pwm2_reload_top #(.DATA_W(DW), .PER_RST(PR)) u_pwm2_reload_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwm_out(pwm_out)
  );

  always #5 clk = ~clk;

  function automatic logic lvl(input logic [DW-1:0] c, input logic [DW-1:0] d,
                               input logic dis, input logic pol);
    return (!dis && c < d) ? pol : ~pol;
  endfunction

  function automatic logic [DW-1:0] rd_of(input logic [2:0] a);
    case (a)
      3'd0: return DW'(m_ctrl);
      3'd1: return m_per_b;
      3'd2: return m_db[0];
      3'd3: return m_db[1];
      3'd4: return DW'(m_arm);
      default: return '0;
    endcase
  endfunction

  task automatic model_reset();
    m_ctrl = 8'h0C; m_per_b = DW'(PR); m_per_w = DW'(PR); m_cnt = '0;
    m_db[0] = '0; m_db[1] = '0; m_dw[0] = '0; m_dw[1] = '0;
    m_lf = 2'b00; m_cyc = 0; m_arm = 0; e_out = 2'b00; e_rd = '0;
  endtask

  task automatic model_step();
    bit pend, rl, xf;
    for (int ch = 0; ch < 2; ch++)
      e_out[ch] = lvl(m_cnt, m_dw[ch], m_ctrl[4+ch], m_ctrl[2+ch]);
    e_rd = rd_of(addr);
    pend = (m_per_w == 0) || (m_cnt == m_per_w - 1);
    rl = pend && (m_cyc == (1 << m_lf) - 1);
    xf = rl && m_arm;
    m_cnt = pend ? '0 : m_cnt + 1'b1;
    if (rl) begin
      m_cyc = 0; m_lf = m_ctrl[7:6];
      if (xf) begin m_per_w = m_per_b; m_dw[0] = m_db[0]; m_dw[1] = m_db[1]; end
    end else if (pend) m_cyc++;
    if (wr_en) begin
      case (addr)
        3'd0: m_ctrl = wdata[7:0];
        3'd1: m_per_b = wdata;
        3'd2: m_db[0] = wdata;
        3'd3: m_db[1] = wdata;
        3'd4: m_arm = wdata[0];
        default: ;
      endcase
    end
    if (xf && !(wr_en && addr == 3'd4)) m_arm = 0;
  endtask

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input bit w, input logic [2:0] a, input logic [DW-1:0] d);
    wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    #2;
    if (!rst) begin
      check(cur_req, DW'(pwm_out), DW'(e_out), "pwm_out");
      check(cur_req, rdata, e_rd, "rdata");
    end
  endtask

  task automatic idle(input int n, input logic [2:0] a);
    for (int i = 0; i < n; i++) tick(1'b0, a, '0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    tick(1'b1, a, d);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_reset();
    idle(4, 3'd0);
    rst = 1'b0;
    // R1: reset values through the read port and the outputs
    cur_req = "R1";
    tick(1'b0, 3'd0, '0); check("R1", rdata, 8'h0C, "ctrl reset");
    tick(1'b0, 3'd1, '0); check("R1", rdata, DW'(PR), "period reset");
    tick(1'b0, 3'd4, '0); check("R1", rdata, '0, "arm reset");
    check("R1", DW'(pwm_out), '0, "outputs reset");

    // R2: period 10, duties 3 and 7, armed
    cur_req = "R2";
    wr(3'd2, 8'd3); wr(3'd3, 8'd7); wr(3'd4, 8'd1);
    idle(40, 3'd4);
    // R9: arm flag cleared by the transfer and set by a write
    cur_req = "R9";
    check("R9", rdata, '0, "arm cleared after transfer");
    wr(3'd4, 8'd1); idle(1, 3'd4); check("R9", rdata, 8'd1, "arm set by write");
    wr(3'd4, 8'd0); idle(1, 3'd4); check("R9", rdata, 8'd0, "arm cleared by write");

    // R6: duty change without arm has no effect at the outputs
    cur_req = "R6";
    wr(3'd2, 8'd8); idle(35, 3'd2);
    wr(3'd4, 8'd1); idle(25, 3'd4);
    // period 0 holds the counter
    wr(3'd1, 8'd0); wr(3'd4, 8'd1); idle(12, 3'd1);
    wr(3'd1, 8'd5); wr(3'd4, 8'd1); idle(12, 3'd1);

    // R3 and R5: each interval setting, duty change armed right after
    for (int lf = 0; lf < 4; lf++) begin
      cur_req = "R5";
      wr(3'd0, DW'({lf[1:0], 6'b001100}));
      idle(1, 3'd0);
      check("R5", rdata, DW'({lf[1:0], 6'b001100}), "ctrl readback");
      cur_req = "R3";
      idle(45, 3'd0);
      wr(3'd2, DW'(1 + lf)); wr(3'd4, 8'd1);
      idle(50, 3'd0);
    end

    // R4: interval change mid-interval with no arm set
    cur_req = "R4";
    idle(7, 3'd0);
    wr(3'd0, 8'b0000_1100);
    idle(60, 3'd0);
    wr(3'd0, 8'b1000_1100); idle(3, 3'd0);
    wr(3'd2, 8'd4); wr(3'd4, 8'd1); idle(60, 3'd0);

    // R7: disable each channel, then re-enable
    cur_req = "R7";
    wr(3'd0, 8'b0001_1100); idle(12, 3'd0);
    wr(3'd0, 8'b0011_1100); idle(12, 3'd0);
    wr(3'd0, 8'b0000_1100); idle(12, 3'd0);

    // R8: polarity combinations, with and without disable
    cur_req = "R8";
    wr(3'd0, 8'b0000_0000); idle(12, 3'd0);
    wr(3'd0, 8'b0000_0100); idle(12, 3'd0);
    wr(3'd0, 8'b0011_0000); idle(12, 3'd0);
    wr(3'd0, 8'b0000_1100); idle(6, 3'd0);

    // R9: write lands in the same clock as a transfer
    cur_req = "R9";
    wr(3'd4, 8'd1);
    for (int i = 0; i < 40; i++) wr(3'd4, 8'd1);
    idle(2, 3'd4);

    // mixed random stimulus, unused addresses included
    cur_req = "R5";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 6) wr(3'($urandom_range(0, 7)), DW'($urandom_range(0, 255)));
      else if (r < 9) wr(3'd1, DW'($urandom_range(0, 12)));
      else if (r < 12) wr(3'd4, 8'd1);
      else idle(1, 3'($urandom_range(0, 7)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule